// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

This block is a memory-mapped event timer. It has one free-running 64-bit up-counter and a parameterized set of comparator channels. Software reaches it through a plain 32-bit word port. Writes take effect on the next clock edge. Reads are combinational from the address. The counter advances by one on every clock while it is enabled. Each channel compares its 32-bit comparator against the low word of the counter and raises an interrupt when the counter reaches that value.

A channel runs either once (one-shot) or repeatedly (periodic). A periodic channel takes two comparator writes: the first one places the first expiry time, and the second one sets the interval that is added after each expiry. Each channel signals either an edge (a one-cycle pulse) or a level (a sticky pending bit that software clears). A global routing bit can move channel 0 onto a dedicated tick line and channel 1 onto a dedicated clock-alarm line. Each channel also holds a pair of route words, which are stored and read back for the fabric outside the block.

Top module: `cmp_event_timer`

## Requirements
- R1: Global config at byte offset 0x08 holds bit 0 = counter run and bit 1 = legacy routing. While run is 0 the counter holds its value. While run is 1 it increases by one per clock. Reset clears the counter and all config to 0.
- R2: The counter reads and writes as a low word at 0x10 and a high word at 0x14. A write to one half loads only that half. The 64-bit count carries from the low word into the high word.
- R3: The capability word at 0x00 reads bits [4:0] = channel count minus one and bit 8 = legacy routing supported, with all other bits 0.
- R4: The word at 0x04 reads the tick period in femtoseconds, a constant set by parameter `PERIOD_FS`.
- R5: The config of channel i sits at 0x20+16*i. Its bits are 0 = level, 1 = enable, 2 = periodic, 3 = periodic-capable (read-only), 4 = message-capable (read-only), 5 = set-value and 6 = force-32-bit. The periodic bit reads 0 on a channel that is not periodic-capable.
- R6: A one-shot channel whose comparator (at 0x24+16*i) is written to counter+d, with d from 1 to 2^31-1, fires exactly once. With counting started, its edge pulse appears d+1 clocks after the clock edge that starts the counter.
- R7: The reach test is wrap-safe: a channel expires when (counter_low − comparator) taken as signed 32 bits is ≥ 0. This covers a comparator that crosses 2^32, a comparator equal to the count and a comparator already passed.
- R8: In periodic mode, a comparator write with set-value 1 loads the comparator and clears set-value. The following comparator write loads the interval and leaves the comparator unchanged. After each expiry the comparator advances by the interval, so pulses repeat every interval clocks.
- R9: An edge-mode channel (level bit 0) outputs a single-cycle pulse per expiry and does not set its status bit.
- R10: A level-mode channel sets bit i of the status word at 0x0C on expiry. Its interrupt output stays high until software writes 1 to that bit, and writing 1 clears it.
- R11: With legacy routing set, channel 0's interrupt appears on `legacyTickIrq` and channel 1's on `legacyRtcIrq`, and `chIrq[0]` and `chIrq[1]` stay 0. With legacy routing clear, both legacy lines are 0.
- R12: Each channel's route data word (0x28+16*i) and route address word (0x2C+16*i) read back exactly what was written.
- R13: A channel with enable 0 raises no interrupt and sets no status bit, even when its comparator has been passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances once per clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| chIrq | output | NUM_CH | Per-channel interrupt outputs |
| legacyTickIrq | output | 1 | Channel 0 interrupt when legacy routing is on |
| legacyRtcIrq | output | 1 | Channel 1 interrupt when legacy routing is on |

## Verification
The main one-shot function is swept over comparator offsets 1 to 8 from two start counts. One start count lies well inside the 32-bit range, and the other lies four below the wrap point, so the offsets either stay below 2^32 or cross it. An off-by-one in the reach test, or a test that is not wrap-safe, therefore shows up as a wrong latency or a missing pulse. Comparators equal to the count and already behind it are tried separately. They separate a ≥ test from a > test and a signed difference from an unsigned one. Periodic runs check the first-expiry latency and three successive intervals. These runs show whether the second write loaded the interval rather than the comparator. Level versus edge delivery, legacy routing and a disabled channel are each tried with a comparator already passed, so every one of them would fire at once if its gating were wrong.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 2 * DATA_W;

  // global register byte offsets
  localparam int OFS_CAP    = 'h00;
  localparam int OFS_PERIOD = 'h04;
  localparam int OFS_GCFG   = 'h08;
  localparam int OFS_STATUS = 'h0C;
  localparam int OFS_CNT_LO = 'h10;
  localparam int OFS_CNT_HI = 'h14;
  localparam int CH_BASE    = 'h20;

  // channel config bit positions
  localparam int CB_LEVEL  = 0;
  localparam int CB_EN     = 1;
  localparam int CB_PER    = 2;
  localparam int CB_PERCAP = 3;
  localparam int CB_MSGCAP = 4;
  localparam int CB_SETVAL = 5;
  localparam int CB_F32    = 6;

  // write strobes from control to datapath
  typedef struct packed {
    logic cntLoWr;
    logic cntHiWr;
    logic gcfgWr;
    logic statusWr;
    logic chCfgWr;
    logic chCmpWr;
    logic chRtDataWr;
    logic chRtAddrWr;
  } evtStrobe_t;
endpackage

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output evtStrobe_t        strobe,
  output logic [NUM_CH-1:0] chSel,
  input  logic [DATA_W-1:0] capWord,
  input  logic [DATA_W-1:0] periodWord,
  input  logic [DATA_W-1:0] gcfgWord,
  input  logic [DATA_W-1:0] statusWord,
  input  logic [CNT_W-1:0]  cntWord,
  input  logic [DATA_W-1:0] chCfgWord  [NUM_CH],
  input  logic [DATA_W-1:0] chCmpWord  [NUM_CH],
  input  logic [DATA_W-1:0] chRtDWord  [NUM_CH],
  input  logic [DATA_W-1:0] chRtAWord  [NUM_CH],
  output logic [DATA_W-1:0] regRdData
);
  localparam int IDX_W = ADDR_W - 4;

  logic              isCh;
  logic [ADDR_W-1:0] chOffset;
  logic [IDX_W-1:0]  chIdx;
  logic [1:0]        chReg;
  logic              chAligned;

  assign isCh      = regAddr >= ADDR_W'(CH_BASE);
  assign chOffset  = regAddr - ADDR_W'(CH_BASE);
  assign chIdx     = chOffset[ADDR_W-1:4];
  assign chReg     = chOffset[3:2];
  assign chAligned = chOffset[1:0] == 2'b00;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign chSel[i] = isCh && chAligned && (chIdx == IDX_W'(i));
  end

  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      if (!isCh) begin
        case (regAddr)
          ADDR_W'(OFS_GCFG):   strobe.gcfgWr   = 1'b1;
          ADDR_W'(OFS_STATUS): strobe.statusWr = 1'b1;
          ADDR_W'(OFS_CNT_LO): strobe.cntLoWr  = 1'b1;
          ADDR_W'(OFS_CNT_HI): strobe.cntHiWr  = 1'b1;
          default: ;
        endcase
      end else if (|chSel) begin
        case (chReg)
          2'd0: strobe.chCfgWr    = 1'b1;
          2'd1: strobe.chCmpWr    = 1'b1;
          2'd2: strobe.chRtDataWr = 1'b1;
          default: strobe.chRtAddrWr = 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (!isCh) begin
      case (regAddr)
        ADDR_W'(OFS_CAP):    regRdData = capWord;
        ADDR_W'(OFS_PERIOD): regRdData = periodWord;
        ADDR_W'(OFS_GCFG):   regRdData = gcfgWord;
        ADDR_W'(OFS_STATUS): regRdData = statusWord;
        ADDR_W'(OFS_CNT_LO): regRdData = cntWord[DATA_W-1:0];
        ADDR_W'(OFS_CNT_HI): regRdData = cntWord[CNT_W-1:DATA_W];
        default: ;
      endcase
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (chSel[i]) begin
          case (chReg)
            2'd0: regRdData = chCfgWord[i];
            2'd1: regRdData = chCmpWord[i];
            2'd2: regRdData = chRtDWord[i];
            default: regRdData = chRtAWord[i];
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter bit PER_CAPABLE = 1'b1,
  parameter bit MSG_CAPABLE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic              cmpWr,
  input  logic              rtDataWr,
  input  logic              rtAddrWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] cntLow,
  output logic [DATA_W-1:0] cfgWord,
  output logic [DATA_W-1:0] cmpWord,
  output logic [DATA_W-1:0] rtDataWord,
  output logic [DATA_W-1:0] rtAddrWord,
  output logic              fire,
  output logic              isLevel
);
  logic              levelQ, enQ, perQ, setValQ, f32Q, armedQ;
  logic [DATA_W-1:0] cmpQ, periodQ, rtDataQ, rtAddrQ;
  logic [DATA_W-1:0] diff;
  logic              reached;

  // wrap-safe reach: signed (count - comparator) >= 0 (R7)
  assign diff    = cntLow - cmpQ;
  assign reached = ~diff[DATA_W-1];
  assign fire    = enQ & armedQ & reached & ~cmpWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ  <= 1'b0;
      enQ     <= 1'b0;
      perQ    <= 1'b0;
      setValQ <= 1'b0;
      f32Q    <= 1'b0;
      armedQ  <= 1'b0;
      cmpQ    <= '0;
      periodQ <= '0;
      rtDataQ <= '0;
      rtAddrQ <= '0;
    end else begin
      if (cfgWr) begin
        levelQ  <= wrData[CB_LEVEL];
        enQ     <= wrData[CB_EN];
        perQ    <= wrData[CB_PER] & PER_CAPABLE;
        setValQ <= wrData[CB_SETVAL];
        f32Q    <= wrData[CB_F32];
      end
      if (cmpWr) begin
        if (perQ && !setValQ) begin
          periodQ <= wrData;          // second write of the periodic pair (R8)
        end else begin
          cmpQ    <= wrData;
          armedQ  <= 1'b1;
          setValQ <= 1'b0;            // self-clearing (R8)
        end
      end else if (fire) begin
        if (perQ) cmpQ <= cmpQ + periodQ;
        else      armedQ <= 1'b0;     // one-shot fires once (R6)
      end
      if (rtDataWr) rtDataQ <= wrData;
      if (rtAddrWr) rtAddrQ <= wrData;
    end
  end

  always_comb begin
    cfgWord            = '0;
    cfgWord[CB_LEVEL]  = levelQ;
    cfgWord[CB_EN]     = enQ;
    cfgWord[CB_PER]    = perQ;
    cfgWord[CB_PERCAP] = PER_CAPABLE;
    cfgWord[CB_MSGCAP] = MSG_CAPABLE;
    cfgWord[CB_SETVAL] = setValQ;
    cfgWord[CB_F32]    = f32Q;
  end

  assign cmpWord    = cmpQ;
  assign rtDataWord = rtDataQ;
  assign rtAddrWord = rtAddrQ;
  assign isLevel    = levelQ;

  AST_SETVAL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cmpWr && setValQ |=> !setValQ); // R8
  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rstN)
    fire && !perQ |=> !fire); // R6
  AST_PERIOD_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    fire && perQ |=> cmpQ == $past(cmpQ) + $past(periodQ)); // R8
endmodule

// File: rtl/evt_datapath.sv
module evt_datapath
  import evt_pkg::*;
#(
  parameter int              NUM_CH     = 3,
  parameter int unsigned     PERIOD_FS  = 69841279,
  parameter bit              LEGACY_CAP = 1'b1,
  parameter logic [NUM_CH-1:0] PER_CAP  = '1,
  parameter logic [NUM_CH-1:0] MSG_CAP  = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  evtStrobe_t        strobe,
  input  logic [NUM_CH-1:0] chSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] capWord,
  output logic [DATA_W-1:0] periodWord,
  output logic [DATA_W-1:0] gcfgWord,
  output logic [DATA_W-1:0] statusWord,
  output logic [CNT_W-1:0]  cntWord,
  output logic [DATA_W-1:0] chCfgWord [NUM_CH],
  output logic [DATA_W-1:0] chCmpWord [NUM_CH],
  output logic [DATA_W-1:0] chRtDWord [NUM_CH],
  output logic [DATA_W-1:0] chRtAWord [NUM_CH],
  output logic [NUM_CH-1:0] chIrq,
  output logic              legacyTickIrq,
  output logic              legacyRtcIrq
);
  logic              runQ, legacyQ;
  logic [CNT_W-1:0]  cntQ;
  logic [NUM_CH-1:0] statusQ, edgeQ;
  logic [NUM_CH-1:0] fire, isLevel, levelFire, rawIrq, clrMask;

  // main counter (R1, R2)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      runQ    <= 1'b0;
      legacyQ <= 1'b0;
    end else begin
      if (strobe.cntLoWr)      cntQ[DATA_W-1:0]     <= wrData;
      else if (strobe.cntHiWr) cntQ[CNT_W-1:DATA_W] <= wrData;
      else if (runQ)           cntQ                 <= cntQ + 1'b1;
      if (strobe.gcfgWr) begin
        runQ    <= wrData[0];
        legacyQ <= wrData[1] & LEGACY_CAP;
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    evt_channel #(
      .PER_CAPABLE(PER_CAP[i]),
      .MSG_CAPABLE(MSG_CAP[i])
    ) i_chan (
      .clk       (clk),
      .rstN      (rstN),
      .cfgWr     (strobe.chCfgWr    & chSel[i]),
      .cmpWr     (strobe.chCmpWr    & chSel[i]),
      .rtDataWr  (strobe.chRtDataWr & chSel[i]),
      .rtAddrWr  (strobe.chRtAddrWr & chSel[i]),
      .wrData    (wrData),
      .cntLow    (cntQ[DATA_W-1:0]),
      .cfgWord   (chCfgWord[i]),
      .cmpWord   (chCmpWord[i]),
      .rtDataWord(chRtDWord[i]),
      .rtAddrWord(chRtAWord[i]),
      .fire      (fire[i]),
      .isLevel   (isLevel[i])
    );
  end

  assign levelFire = fire & isLevel;
  assign clrMask   = strobe.statusWr ? wrData[NUM_CH-1:0] : '0;

  // level pending bits (R10) and edge pulses (R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      edgeQ   <= '0;
    end else begin
      statusQ <= (statusQ & ~clrMask) | levelFire;
      edgeQ   <= fire & ~isLevel;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_irq
    assign rawIrq[i] = isLevel[i] ? statusQ[i] : edgeQ[i];
  end

  // legacy routing (R11)
  if (NUM_CH >= 2) begin : g_legacy
    always_comb begin
      chIrq         = rawIrq;
      legacyTickIrq = 1'b0;
      legacyRtcIrq  = 1'b0;
      if (legacyQ) begin
        chIrq[1:0]    = 2'b00;
        legacyTickIrq = rawIrq[0];
        legacyRtcIrq  = rawIrq[1];
      end
    end
  end else begin : g_nolegacy
    assign chIrq         = rawIrq;
    assign legacyTickIrq = 1'b0;
    assign legacyRtcIrq  = 1'b0;
  end

  assign capWord    = {23'd0, LEGACY_CAP, 3'd0, 5'(NUM_CH - 1)};
  assign periodWord = DATA_W'(PERIOD_FS);
  assign gcfgWord   = {30'd0, legacyQ, runQ};
  assign statusWord = DATA_W'(statusQ);
  assign cntWord    = cntQ;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !runQ && !strobe.cntLoWr && !strobe.cntHiWr |=> $stable(cntQ)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    runQ && !strobe.cntLoWr && !strobe.cntHiWr && !strobe.gcfgWr |=> cntQ == $past(cntQ) + 1'b1); // R1

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ast
    AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rstN)
      clrMask[i] && !levelFire[i] |=> !statusQ[i]); // R10
    AST_EDGE_NO_STATUS: assert property (@(posedge clk) disable iff (!rstN)
      fire[i] && !isLevel[i] && !statusQ[i] |=> !statusQ[i]); // R9
  end
endmodule

// File: rtl/cmp_event_timer.sv
module cmp_event_timer
  import evt_pkg::*;
#(
  parameter int                NUM_CH     = 3,
  parameter int                ADDR_W     = 8,
  parameter int unsigned       PERIOD_FS  = 69841279,
  parameter bit                LEGACY_CAP = 1'b1,
  parameter logic [NUM_CH-1:0] PER_CAP    = 3'b011,
  parameter logic [NUM_CH-1:0] MSG_CAP    = 3'b110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic [NUM_CH-1:0] chIrq,
  output logic              legacyTickIrq,
  output logic              legacyRtcIrq
);
  evtStrobe_t        strobe;
  logic [NUM_CH-1:0] chSel;
  logic [DATA_W-1:0] capWord, periodWord, gcfgWord, statusWord;
  logic [CNT_W-1:0]  cntWord;
  logic [DATA_W-1:0] chCfgWord [NUM_CH];
  logic [DATA_W-1:0] chCmpWord [NUM_CH];
  logic [DATA_W-1:0] chRtDWord [NUM_CH];
  logic [DATA_W-1:0] chRtAWord [NUM_CH];

  evt_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_ctrl (
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .strobe    (strobe),
    .chSel     (chSel),
    .capWord   (capWord),
    .periodWord(periodWord),
    .gcfgWord  (gcfgWord),
    .statusWord(statusWord),
    .cntWord   (cntWord),
    .chCfgWord (chCfgWord),
    .chCmpWord (chCmpWord),
    .chRtDWord (chRtDWord),
    .chRtAWord (chRtAWord),
    .regRdData (regRdData)
  );

  evt_datapath #(
    .NUM_CH    (NUM_CH),
    .PERIOD_FS (PERIOD_FS),
    .LEGACY_CAP(LEGACY_CAP),
    .PER_CAP   (PER_CAP),
    .MSG_CAP   (MSG_CAP)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .chSel        (chSel),
    .wrData       (regWrData),
    .capWord      (capWord),
    .periodWord   (periodWord),
    .gcfgWord     (gcfgWord),
    .statusWord   (statusWord),
    .cntWord      (cntWord),
    .chCfgWord    (chCfgWord),
    .chCmpWord    (chCmpWord),
    .chRtDWord    (chRtDWord),
    .chRtAWord    (chRtAWord),
    .chIrq        (chIrq),
    .legacyTickIrq(legacyTickIrq),
    .legacyRtcIrq (legacyRtcIrq)
  );
endmodule

// File: tb/test_cmp_event_timer.sv
module test_cmp_event_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [2:0]  chIrq;
  logic        legacyTickIrq, legacyRtcIrq;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [31:0] v;
  int n;

  cmp_event_timer i_cmp_event_timer (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .chIrq(chIrq),
    .legacyTickIrq(legacyTickIrq), .legacyRtcIrq(legacyRtcIrq)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [4:0] irqVec();
    return {legacyRtcIrq, legacyTickIrq, chIrq};
  endfunction

  task automatic waitIrq(input int sel, input int limit, output int cnt);
    cnt = 0;
    while (!irqVec()[sel] && cnt < limit) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  function automatic logic [7:0] chA(input int ch, input int r);
    return 8'(32'h20 + 16 * ch + 4 * r);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state (R1)
    rd(8'h08, v); check("R1 reset gcfg", v, 0);
    rd(8'h10, v); check("R1 reset cnt", v, 0);
    rd(8'h0C, v); check("R10 reset status", v, 0);
    check("R11 reset irqs", 32'(irqVec()), 0);

    // R3 / R4
    rd(8'h00, v); check("R3 capability", v, 32'h102);
    rd(8'h04, v); check("R4 period", v, 32'd69841279);

    // R5 config layout and read-only caps
    wr(chA(0, 0), 32'h7F); rd(chA(0, 0), v); check("R5 ch0 cfg", v, 32'h6F);
    wr(chA(1, 0), 32'h7F); rd(chA(1, 0), v); check("R5 ch1 cfg", v, 32'h7F);
    wr(chA(2, 0), 32'h7F); rd(chA(2, 0), v); check("R5 ch2 cfg", v, 32'h73);
    for (int c = 0; c < 3; c++) wr(chA(c, 0), 0);

    // R12 route words
    for (int c = 0; c < 3; c++) begin
      wr(chA(c, 2), 32'hA5A50000 + 32'(c));
      wr(chA(c, 3), 32'hFEE00000 + 32'(c * 16));
    end
    for (int c = 0; c < 3; c++) begin
      rd(chA(c, 2), v); check("R12 route data", v, 32'hA5A50000 + 32'(c));
      rd(chA(c, 3), v); check("R12 route addr", v, 32'hFEE00000 + 32'(c * 16));
    end

    // R2 counter halves, R1 hold and run
    wr(8'h10, 32'h12345678); wr(8'h14, 32'h0000000A);
    rd(8'h10, v); check("R2 cnt lo", v, 32'h12345678);
    rd(8'h14, v); check("R2 cnt hi", v, 32'h0000000A);
    repeat (5) @(negedge clk);
    rd(8'h10, v); check("R1 hold", v, 32'h12345678);
    wr(8'h10, 32'hFFFFFFFD); wr(8'h14, 0);
    wr(8'h08, 1);
    repeat (5) @(negedge clk);
    rd(8'h14, v); check("R2 carry hi", v, 1);
    rd(8'h10, v); check("R1 run lo", v, 2);
    wr(8'h08, 0);

    // R6 / R7 one-shot sweep, edge mode on channel 1
    for (int s = 0; s < 2; s++) begin
      for (int d = 1; d <= 8; d++) begin
        logic [31:0] c0;
        int extra;
        c0 = (s == 0) ? 32'd1000 : 32'hFFFFFFFC;
        wr(8'h08, 0);
        wr(8'h10, c0); wr(8'h14, 0);
        wr(chA(1, 0), 32'h2);
        wr(chA(1, 1), c0 + 32'(d));
        wr(8'h08, 1);
        waitIrq(1, 60, n);
        check(s == 0 ? "R6 one-shot latency" : "R7 wrap latency", 32'(n), 32'(d + 1));
        @(negedge clk);
        check("R9 pulse width", 32'(chIrq[1]), 0);
        extra = 0;
        for (int k = 0; k < 20; k++) begin
          @(negedge clk);
          if (chIrq[1]) extra++;
        end
        check("R6 fires once", 32'(extra), 0);
      end
    end
    rd(8'h0C, v); check("R9 edge sets no status", v, 0);

    // R7 comparator equal and behind
    wr(8'h08, 0); wr(8'h10, 500);
    wr(chA(1, 1), 500);
    waitIrq(1, 20, n); check("R7 equal fires", 32'(n), 1);
    wr(chA(1, 1), 497);
    waitIrq(1, 20, n); check("R7 behind fires", 32'(n), 1);
    wr(chA(1, 0), 0);

    // R8 periodic two-write sequence on channel 0
    wr(8'h10, 100);
    wr(chA(0, 0), 32'h26);
    wr(chA(0, 1), 103);
    rd(chA(0, 0), v); check("R8 set-value cleared", v, 32'h0E);
    wr(chA(0, 1), 7);
    rd(chA(0, 1), v); check("R8 comparator kept", v, 103);
    wr(8'h08, 1);
    waitIrq(0, 60, n); check("R8 first expiry", 32'(n), 4);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      waitIrq(0, 60, n);
      check("R8 interval", 32'(n + 1), 7);
    end
    wr(8'h08, 0); wr(chA(0, 0), 0);

    // R10 level mode on channel 2
    wr(8'h10, 50);
    wr(chA(2, 0), 32'h3);
    wr(chA(2, 1), 40);
    waitIrq(2, 20, n); check("R10 level fires", 32'(n), 1);
    repeat (5) @(negedge clk);
    check("R10 level held", 32'(chIrq[2]), 1);
    rd(8'h0C, v); check("R10 status bit", v, 4);
    wr(8'h0C, 4);
    check("R10 cleared irq", 32'(chIrq[2]), 0);
    rd(8'h0C, v); check("R10 cleared status", v, 0);

    // R13 disabled channel
    wr(chA(2, 0), 32'h1);
    wr(chA(2, 1), 40);
    repeat (5) @(negedge clk);
    check("R13 no irq", 32'(chIrq[2]), 0);
    rd(8'h0C, v); check("R13 no status", v, 0);
    wr(chA(2, 0), 0);

    // R11 legacy routing
    wr(8'h08, 2);
    rd(8'h08, v); check("R11 gcfg", v, 2);
    wr(chA(0, 0), 32'h2);
    wr(chA(0, 1), 10);
    waitIrq(3, 20, n); check("R11 tick line", 32'(n), 1);
    check("R11 ch0 masked", 32'(chIrq[0]), 0);
    wr(chA(1, 0), 32'h3);
    wr(chA(1, 1), 10);
    waitIrq(4, 20, n); check("R11 rtc line", 32'(n), 1);
    check("R11 ch1 masked", 32'(chIrq[1]), 0);
    wr(8'h0C, 2);
    check("R11 rtc cleared", 32'(legacyRtcIrq), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule